// File: doc/BRIEF.md
# Mersenne-Modulus Residue Check Tracker

This block runs beside a 1's-complement accumulator and keeps a small check register that should always hold the accumulator's value modulo A = 2^W - 1. W is the residue width and must divide the accumulator width N. Whenever the accumulator performs an operation, the tracker applies a matching operation in the residue domain in the same cycle. The operations are load, add, complement, rotate-left-by-one and shift-left-by-one with zero fill. The tracker never recomputes the residue from the result.

Each cycle the block folds the current accumulator word into its residue by adding its W-bit chunks with end-around carry. It then outputs the syndrome (residue(X) - Y) mod A, where X is the accumulator and Y is the check register. A zero syndrome means the two agree. A nonzero syndrome gives the signed offset that a downstream decoder can use to locate and correct a fault. That decoder is not part of this block.

Top module: `resid_track`

## Requirements
- R1: While `rst` is high at a rising edge, the check register becomes 0 whatever the opcode is.
- R2: The check register only ever holds values 0..A-1. An all-ones residue is stored as 0, so loading an all-ones word yields 0.
- R3: Opcode 1 (load) sets the check register to residue(`operand_i`) at the next edge.
- R4: Opcode 2 (add) sets the check register to (Y + residue(`operand_i`)) mod A, which matches an end-around-carry sum of the accumulator and the operand.
- R5: Opcode 3 (complement) sets the check register to (-Y) mod A, which is the bitwise inverse of Y with 0 kept at 0.
- R6: Opcode 4 (rotate) rotates the W-bit check register left by one position.
- R7: Opcode 5 (shift) sets the check register to (2Y - m) mod A, where m is `acc_i[N-1]` sampled at that edge.
- R8: Opcodes 0, 6 and 7 leave the check register unchanged.
- R9: When the check register matches residue(`acc_i`), `syndrome_o` is 0. It is combinational from `acc_i` and the check register.
- R10: `syndrome_o` equals (residue(`acc_i`) - Y) mod A, in the range 0..A-1, for any `acc_i`.
- R11: Flipping any single bit of a consistent `acc_i` gives a nonzero syndrome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Opcode of the accumulator operation in this cycle |
| operand_i | input | N | Word loaded into or added to the accumulator |
| acc_i | input | N | Current accumulator value; its top bit is the bit that a shift moves out |
| chk_o | output | W | Check register (tracked residue) |
| syndrome_o | output | W | (residue(acc_i) - check) mod A |

## Verification
The bench targets the wrap points of the modulus:
- Complementing a zero residue: a wrong design would store all-ones, the second encoding of zero, and report a false syndrome later.
- An add whose accumulator sum carries out: a design without end-around carry would drift by one.
- A shift that moves out a one: a design that ignores the lost bit would be off by one.
- An all-ones word loaded: a design that does not normalise would store 7 instead of 0.

Every single-bit flip of the accumulator is then injected. A wrong subtraction direction or a missing normalisation would give the wrong syndrome value, or zero, for some bit position.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 3'd0,
        OP_LOAD = 3'd1,
        OP_ADD  = 3'd2,
        OP_COMP = 3'd3,
        OP_ROTL = 3'd4,
        OP_SHL  = 3'd5
    } rt_op_e;

endpackage

// File: rtl/rt_madd.sv
// Addition modulo 2^W-1 with end-around carry; the result is normalised (all-ones -> 0).
module rt_madd #(
    parameter int W = 3
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] s_o
);
    localparam logic [W-1:0] ALL1 = '1;

    logic [W:0]   raw;
    logic [W-1:0] wrapped;

    always_comb begin
        raw     = {1'b0, a_i} + {1'b0, b_i};
        wrapped = raw[W-1:0] + W'(raw[W]);
        s_o     = (wrapped == ALL1) ? '0 : wrapped;
    end
endmodule

// File: rtl/rt_fold.sv
// Residue generator: chains W-bit chunk additions modulo 2^W-1.
module rt_fold #(
    parameter int N = 12,
    parameter int W = 3
) (
    input  logic [N-1:0] word_i,
    output logic [W-1:0] res_o
);
    localparam int CH = N / W;

    logic [W-1:0] part [CH+1];

    assign part[0] = '0;

    for (genvar i = 0; i < CH; i++) begin : g_chunk
        rt_madd #(.W(W)) u_m (
            .a_i(part[i]),
            .b_i(word_i[i*W +: W]),
            .s_o(part[i+1])
        );
    end

    assign res_o = part[CH];
endmodule

// File: rtl/rt_next.sv
// Residue-domain twin of each accumulator operation.
module rt_next #(
    parameter int W = 3
) (
    input  rt_pkg::rt_op_e op_i,
    input  logic [W-1:0]   chk_i,
    input  logic [W-1:0]   opnd_res_i,
    input  logic           msb_out_i,
    output logic [W-1:0]   chk_d_o
);
    import rt_pkg::*;

    localparam logic [W-1:0] MINUS1 = {{(W-1){1'b1}}, 1'b0};

    logic [W-1:0] rot_v;
    logic [W-1:0] comp_v;
    logic [W-1:0] add_v;
    logic [W-1:0] shl_v;
    logic [W-1:0] shl_sub;

    assign rot_v   = {chk_i[W-2:0], chk_i[W-1]};
    assign comp_v  = (chk_i == '0) ? '0 : ~chk_i;
    assign shl_sub = msb_out_i ? MINUS1 : '0;

    rt_madd #(.W(W)) u_add (.a_i(chk_i), .b_i(opnd_res_i), .s_o(add_v));
    rt_madd #(.W(W)) u_shl (.a_i(rot_v), .b_i(shl_sub),    .s_o(shl_v));

    always_comb begin
        case (op_i)
            OP_LOAD: chk_d_o = opnd_res_i;
            OP_ADD:  chk_d_o = add_v;
            OP_COMP: chk_d_o = comp_v;
            OP_ROTL: chk_d_o = rot_v;
            OP_SHL:  chk_d_o = shl_v;
            default: chk_d_o = chk_i;
        endcase
    end
endmodule

// File: rtl/rt_syndrome.sv
// Syndrome = (residue(acc) - check) mod A; -Y mod A is ~Y within W bits.
module rt_syndrome #(
    parameter int N = 12,
    parameter int W = 3
) (
    input  logic [N-1:0] acc_i,
    input  logic [W-1:0] chk_i,
    output logic [W-1:0] acc_res_o,
    output logic [W-1:0] syn_o
);
    logic [W-1:0] neg_chk;

    rt_fold #(.N(N), .W(W)) u_fold (.word_i(acc_i), .res_o(acc_res_o));

    assign neg_chk = ~chk_i;

    rt_madd #(.W(W)) u_sub (.a_i(acc_res_o), .b_i(neg_chk), .s_o(syn_o));
endmodule

// File: rtl/resid_track.sv
module resid_track #(
    parameter int N = 12,
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   op_i,
    input  logic [N-1:0] operand_i,
    input  logic [N-1:0] acc_i,
    output logic [W-1:0] chk_o,
    output logic [W-1:0] syndrome_o
);
    import rt_pkg::*;

    localparam logic [W-1:0] ALL1 = '1;

    rt_op_e       op;
    logic [W-1:0] chk_q;
    logic [W-1:0] chk_d;
    logic [W-1:0] opnd_res;
    logic [W-1:0] acc_res;

    assign op = rt_op_e'(op_i);

    rt_fold #(.N(N), .W(W)) u_opfold (.word_i(operand_i), .res_o(opnd_res));

    rt_next #(.W(W)) u_next (
        .op_i(op), .chk_i(chk_q), .opnd_res_i(opnd_res),
        .msb_out_i(acc_i[N-1]), .chk_d_o(chk_d)
    );

    rt_syndrome #(.N(N), .W(W)) u_syn (
        .acc_i(acc_i), .chk_i(chk_q), .acc_res_o(acc_res), .syn_o(syndrome_o)
    );

    always_ff @(posedge clk) begin
        if (rst) chk_q <= '0;
        else     chk_q <= chk_d;
    end

    assign chk_o = chk_q;

    p_rst_clear_r1: assert property (@(posedge clk) rst |=> chk_q == '0);

    p_norm_r2: assert property (@(posedge clk) disable iff (rst) chk_q != ALL1);

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> chk_q == $past(opnd_res));

    p_add_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD && opnd_res == '0) |=> $stable(chk_q));

    p_add_from0_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD && chk_q == '0) |=> chk_q == $past(opnd_res));

    p_comp_r5: assert property (@(posedge clk) disable iff (rst)
        op == OP_COMP |=> chk_q == (($past(chk_q) == '0) ? '0 : ~$past(chk_q)));

    p_rot_r6: assert property (@(posedge clk) disable iff (rst)
        op == OP_ROTL |=> chk_q == {$past(chk_q[W-2:0]), $past(chk_q[W-1])});

    p_shl_nomsb_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHL && !acc_i[N-1]) |=> chk_q == {$past(chk_q[W-2:0]), $past(chk_q[W-1])});

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0 || op_i == 3'd6 || op_i == 3'd7) |=> $stable(chk_q));

    p_syn_zero_r9: assert property (@(posedge clk) disable iff (rst)
        acc_res == chk_q |-> syndrome_o == '0);

    p_syn_range_r10: assert property (@(posedge clk) disable iff (rst)
        syndrome_o != ALL1);
endmodule

// File: tb/sim_resid_track.sv
module sim_resid_track;
    localparam int N = 12;
    localparam int W = 3;
    localparam int A = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   op = 3'd0;
    logic [N-1:0] opnd = '0;
    logic [N-1:0] acc = '0;
    logic [W-1:0] chk_o;
    logic [W-1:0] syn_o;

    logic [N-1:0] X = '0;
    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    resid_track #(.N(N), .W(W)) u0 (
        .clk(clk), .rst(rst), .op_i(op), .operand_i(opnd), .acc_i(acc),
        .chk_o(chk_o), .syndrome_o(syn_o)
    );

    function automatic int resid(logic [N-1:0] v);
        return int'(v) % A;
    endfunction

    function automatic logic [N-1:0] acc_next(logic [N-1:0] x, logic [2:0] o, logic [N-1:0] d);
        logic [N:0] s;
        case (o)
            3'd1: return d;
            3'd2: begin
                s = {1'b0, x} + {1'b0, d};
                return s[N-1:0] + N'(s[N]);
            end
            3'd3: return ~x;
            3'd4: return {x[N-2:0], x[N-1]};
            3'd5: return {x[N-2:0], 1'b0};
            default: return x;
        endcase
    endfunction

    function automatic string op_tag(logic [2:0] o);
        case (o)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic apply(logic [2:0] o, logic [N-1:0] d);
        op   = o;
        opnd = d;
        @(posedge clk);
        X = acc_next(X, o, d);
        @(negedge clk);
        op  = 3'd0;
        acc = X;
        #1;
        check(op_tag(o), int'(chk_o), resid(X));
        check("R9", int'(syn_o), 0);
    endtask

    task automatic inject_all;
        for (int j = 0; j < N; j++) begin
            logic [N-1:0] xe;
            xe  = X ^ (N'(1) << j);
            acc = xe;
            #1;
            check("R10", int'(syn_o), (resid(xe) - resid(X) + A) % A);
            check("R11", int'(syn_o != '0), 1);
        end
        acc = X;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        op   = 3'd1;
        opnd = 12'h5a5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(chk_o), 0);
        rst = 1'b0;
        op  = 3'd0;
        X   = '0;
        acc = X;
        #1;
        check("R1", int'(syn_o), 0);

        // directed corners
        apply(3'd3, '0);            // complement of zero residue (R5)
        apply(3'd1, '1);            // all-ones word -> residue 0 (R2)
        check("R2", int'(chk_o), 0);
        apply(3'd1, 12'hfff - 12'd1);
        apply(3'd2, 12'h003);       // end-around carry add (R4)
        apply(3'd1, 12'h801);
        apply(3'd5, '0);            // shift moves out a one (R7)
        apply(3'd4, '0);            // rotate (R6)
        apply(3'd6, 12'h123);       // undefined opcode holds (R8)
        apply(3'd7, 12'habc);
        apply(3'd0, 12'h777);
        inject_all();

        for (int k = 0; k < 400; k++) begin
            logic [2:0] o;
            o = 3'($urandom_range(0, 7));
            apply(o, N'($urandom));
            if (k % 50 == 0) inject_all();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule